// File: doc/BRIEF.md
# Packet-Stream I2C Master

This block is an I2C bus master that takes its work as a stream of 32-bit command words rather than per-byte register writes. Each transaction enters the TX stream as three header words followed by the payload words. The first header is a generic word, the second gives the length, and the third holds the address byte and the direction and ending flags. The engine pops the headers, issues START, sends the address byte and moves the payload over SCL/SDA. It then ends with STOP, or with the bus held for a repeated START. Payload bytes are packed four to a word in little-endian order. Bytes read from the bus come back as packed words on the RX stream.

Completion, a missing acknowledge and lost arbitration are latched in a three-bit status vector. A status bit is cleared by writing a one to it. Two counts report free TX slots and filled RX slots. After an error the engine stops taking words until reset, and reset empties both FIFOs. SCL comes from a divider of the core clock, set by the `scl_half` input. Each SCL phase lasts `scl_half` core cycles, and one bit takes four phases.

Both data streams use valid/ready. A TX word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low exactly while the TX FIFO is full. An RX word is handed over on an edge where `rx_valid` and `rx_ready` are both high. While `rx_ready` is low, `rx_data` holds its value.

Top module: `i2cpk_master`

## Requirements
- R1: A transaction uses exactly three header words, taken in the order generic, length, I2C. Bits 11:0 of the length word hold the byte count minus one, so 0 means one byte. After a successful transaction none of its TX words remain queued, and `tx_free` is back to FIFO_DEPTH.
- R2: After START the engine sends bits 7:0 of the I2C header word unchanged as the address byte. Bit 19 of that word set selects a read data phase, and clear selects a write data phase.
- R3: Written bytes go out from bits 7:0 of a word first, then bits 15:8, 23:16 and 31:24, each byte MSB first. The engine consumes ceil(n/4) payload words, and bytes of the last word beyond the count never reach the bus. SDA changes only while SCL is low during data bits.
- R4: Read bytes are packed the same little-endian way into ceil(n/4) RX words, and the unused upper bytes of the last word are zero. The master ACKs every read byte except the last, which it NACKs.
- R5: When bit 16 of the I2C header word is set, the transaction ends without STOP and with SCL held low. The next transaction then opens with a repeated START.
- R6: Status bit 0 (done) is set when a transaction ends without error. This happens after STOP, or after the last byte when R5 applies.
- R7: A NACK to the address or to a written byte sets status bit 1 and does not set bit 0. The engine then drives STOP and consumes no further TX words until reset.
- R8: If SDA reads low while the master releases it in an address or write bit, status bit 2 is set and bit 0 is not. SCL and SDA are released within two cycles and the engine halts.
- R9: A 1 in a bit of `sts_clr` clears that status bit. A 0 leaves the bit unchanged.
- R10: Reset gives `tx_free` = FIFO_DEPTH, `rx_fill` = 0, status 0, SCL high and SDA not driven. Reset also discards queued TX words.
- R11: `tx_ready` is low exactly when `tx_free` is 0. `rx_data` stays stable while `rx_valid` is high and `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, flushes FIFOs |
| scl_half | input | DIVW | Core cycles per SCL quarter-bit phase |
| tx_valid | input | 1 | TX command/payload word valid |
| tx_ready | output | 1 | TX FIFO can accept a word |
| tx_data | input | 32 | TX word |
| rx_valid | output | 1 | RX word available |
| rx_ready | input | 1 | Consumer takes the RX word |
| rx_data | output | 32 | RX packed read data |
| tx_free | output | CW | Empty TX slots |
| rx_fill | output | CW | Filled RX slots |
| irq_sts | output | 3 | Status: 0 done, 1 nack, 2 arbitration lost |
| sts_clr | input | 3 | Write-one-to-clear strobes for irq_sts |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA bus level |

## Verification
The bench uses the default FIFO_DEPTH of 8 and sets `scl_half` to 2. With that short divider, a whole multi-word transaction takes well under a thousand cycles, so the bench can walk many transactions and error cases in one run. With a depth of 8 the TX FIFO fills within a few pushes once the engine halts, so the full condition and the freeze after an error can both be seen. An eight-byte write also fits in one queue load of headers plus payload.

// File: rtl/i2cpk_pkg.sv
package i2cpk_pkg;
  localparam int LEN_W  = 12;
  localparam int RD_BIT = 19;
  localparam int RS_BIT = 16;

  typedef enum logic [1:0] {PH_START, PH_WRITE, PH_READ, PH_STOP} phy_op_e;
  typedef enum logic [2:0] {S_HDR0, S_HDR1, S_HDR2, S_START, S_ADDR, S_DATA, S_STOP, S_HALT} ctl_e;
endpackage

// File: rtl/i2cpk_fifo.sv
module i2cpk_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
endmodule

// File: rtl/i2cpk_phy.sv
module i2cpk_phy
  import i2cpk_pkg::*;
#(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] scl_half,
  input  logic            op_valid,
  input  phy_op_e         op,
  input  logic [7:0]      op_byte,
  input  logic            op_nack,
  output logic            op_ready,
  output logic            done,
  output logic [7:0]      rd_byte,
  output logic            got_nack,
  output logic            arb_lost,
  output logic            scl_o,
  output logic            sda_oe,
  input  logic            sda_i
);
  logic            busy, own, ack_q, nack_q;
  phy_op_e         op_q;
  logic [1:0]      ph;
  logic [3:0]      bitn;
  logic [7:0]      sh;
  logic [DIVW-1:0] tmr, lim;
  logic            tick, last, bit_val, scl_d, low_d, data_op;

  assign lim      = (scl_half == '0) ? '0 : scl_half - 1'b1;
  assign tick     = busy && (tmr >= lim);
  assign data_op  = (op_q == PH_WRITE) || (op_q == PH_READ);
  assign last     = !data_op || (bitn == 4'd8);
  assign op_ready = !busy;
  assign rd_byte  = sh;
  assign got_nack = nack_q;
  assign done     = tick && (ph == 2'd3) && last;
  assign arb_lost = tick && (ph == 2'd2) && (op_q == PH_WRITE) && (bitn < 4'd8) && sh[7] && !sda_i;

  always_comb begin
    if (bitn < 4'd8) bit_val = (op_q == PH_WRITE) ? sh[7] : 1'b1;
    else             bit_val = (op_q == PH_WRITE) ? 1'b1 : ack_q;
    scl_d = !own;
    low_d = 1'b0;
    if (busy) begin
      case (op_q)
        PH_START: begin scl_d = (ph == 2'd0) ? !own : (ph != 2'd3); low_d = ph[1]; end
        PH_STOP:  begin scl_d = (ph != 2'd0); low_d = (ph < 2'd2); end
        default:  begin scl_d = (ph == 2'd1) || (ph == 2'd2); low_d = !bit_val; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; own <= 1'b0; ack_q <= 1'b0; nack_q <= 1'b0; op_q <= PH_START;
      ph <= '0; bitn <= '0; sh <= '0; tmr <= '0; scl_o <= 1'b1; sda_oe <= 1'b0;
    end else begin
      scl_o  <= scl_d;
      sda_oe <= low_d;
      if (op_valid && !busy) begin
        busy <= 1'b1; op_q <= op; ph <= '0; bitn <= '0; sh <= op_byte;
        ack_q <= op_nack; nack_q <= 1'b0; tmr <= '0;
      end else if (busy) begin
        tmr <= tick ? '0 : tmr + 1'b1;
        if (arb_lost) begin
          busy <= 1'b0; own <= 1'b0;
        end else if (tick) begin
          if (ph == 2'd2 && data_op && bitn < 4'd8) sh <= {sh[6:0], sda_i};
          if (ph == 2'd2 && op_q == PH_WRITE && bitn == 4'd8) nack_q <= sda_i;
          if (ph == 2'd3) begin
            ph <= '0;
            if (last) begin busy <= 1'b0; own <= (op_q != PH_STOP); end
            else bitn <= bitn + 1'b1;
          end else ph <= ph + 1'b1;
        end
      end
    end
  end

  // R3
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_op && scl_o && $past(scl_o)) |-> $stable(sda_oe));
endmodule

// File: rtl/i2cpk_master.sv
module i2cpk_master
  import i2cpk_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIVW = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] scl_half,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [31:0]     tx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [31:0]     rx_data,
  output logic [CW-1:0]   tx_free,
  output logic [CW-1:0]   rx_fill,
  output logic [2:0]      irq_sts,
  input  logic [2:0]      sts_clr,
  output logic            scl_o,
  output logic            sda_oe,
  input  logic            sda_i
);
  localparam int LW = LEN_W + 1;

  logic          tq_valid, tq_pop, rq_push, rq_ready;
  logic [31:0]   tq_data, rq_data, word_q, rxw_q;
  logic [CW-1:0] tx_cnt;
  ctl_e          st;
  logic          pend, rd_q, rs_q, err_q;
  logic [7:0]    addr_q;
  logic [LW-1:0] left;
  logic [1:0]    bi;
  logic          op_valid, op_ready, op_nack, phy_done, phy_nack, phy_arb;
  phy_op_e       op;
  logic [7:0]    op_byte, rd_byte;
  logic [2:0]    set_vec;
  logic          wr_nack, lastb;

  i2cpk_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(tq_valid), .out_ready(tq_pop), .out_data(tq_data), .count(tx_cnt));

  i2cpk_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .in_valid(rq_push), .in_ready(rq_ready), .in_data(rq_data),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data), .count(rx_fill));

  i2cpk_phy #(.DIVW(DIVW)) u_phy (
    .clk, .rst_n, .scl_half, .op_valid, .op, .op_byte, .op_nack, .op_ready,
    .done(phy_done), .rd_byte, .got_nack(phy_nack), .arb_lost(phy_arb),
    .scl_o, .sda_oe, .sda_i);

  assign tx_free = CW'(FIFO_DEPTH) - tx_cnt;
  assign lastb   = (left == LW'(1));
  assign wr_nack = phy_nack && !(st == S_DATA && rd_q);
  assign rq_push = (st == S_DATA) && rd_q && phy_done && (bi == 2'd3 || lastb);
  assign rq_data = rxw_q | ({24'b0, rd_byte} << {bi, 3'b000});

  always_comb begin
    op_valid = 1'b0; op = PH_START; op_byte = addr_q; op_nack = 1'b0; tq_pop = 1'b0;
    case (st)
      S_HDR0, S_HDR1, S_HDR2: tq_pop = tq_valid;
      S_START: op_valid = !pend;
      S_ADDR:  begin op = PH_WRITE; op_valid = !pend; end
      S_DATA: begin
        if (rd_q) begin
          op = PH_READ; op_nack = lastb;
          op_valid = !pend && (bi != 2'd0 || rq_ready);
        end else begin
          op = PH_WRITE;
          op_byte = (bi == 2'd0) ? tq_data[7:0] : word_q[{bi, 3'b000} +: 8];
          op_valid = !pend && (bi != 2'd0 || tq_valid);
          tq_pop = op_valid && op_ready && (bi == 2'd0);
        end
      end
      S_STOP: begin op = PH_STOP; op_valid = !pend; end
      default: ;
    endcase
  end

  always_comb begin
    set_vec    = 3'b000;
    set_vec[0] = phy_done && ((st == S_DATA && lastb && rs_q && !wr_nack) || (st == S_STOP && !err_q));
    set_vec[1] = phy_done && (st == S_STOP) && err_q;
    set_vec[2] = phy_arb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HDR0; pend <= 1'b0; rd_q <= 1'b0; rs_q <= 1'b0; err_q <= 1'b0;
      addr_q <= '0; left <= '0; bi <= '0; word_q <= '0; rxw_q <= '0; irq_sts <= '0;
    end else begin
      irq_sts <= (irq_sts & ~sts_clr) | set_vec;
      if (op_valid && op_ready) pend <= 1'b1;
      if (phy_done) pend <= 1'b0;
      if (phy_arb) begin
        st <= S_HALT; pend <= 1'b0;
      end else begin
        case (st)
          S_HDR0: if (tq_valid) st <= S_HDR1;
          S_HDR1: if (tq_valid) begin left <= {1'b0, tq_data[LEN_W-1:0]} + 1'b1; st <= S_HDR2; end
          S_HDR2: if (tq_valid) begin
            addr_q <= tq_data[7:0]; rd_q <= tq_data[RD_BIT]; rs_q <= tq_data[RS_BIT]; st <= S_START;
          end
          S_START: if (phy_done) st <= S_ADDR;
          S_ADDR: if (phy_done) begin
            if (phy_nack) begin err_q <= 1'b1; st <= S_STOP; end
            else begin st <= S_DATA; bi <= '0; rxw_q <= '0; end
          end
          S_DATA: begin
            if (tq_pop) word_q <= tq_data;
            if (phy_done) begin
              if (wr_nack) begin err_q <= 1'b1; st <= S_STOP; end
              else begin
                bi <= bi + 1'b1; left <= left - 1'b1;
                if (rd_q) rxw_q <= rq_push ? '0 : rq_data;
                if (lastb) st <= rs_q ? S_HDR0 : S_STOP;
              end
            end
          end
          S_STOP: if (phy_done) st <= err_q ? S_HALT : S_HDR0;
          default: ;
        endcase
      end
    end
  end

  // R7
  halt_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT) |-> !tq_pop);
  // R6
  done_vs_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sts[1]) |-> !$rose(irq_sts[0]));
  // R8
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_arb |=> ##1 (scl_o && !sda_oe));
  // R11
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready == (tx_free != '0));
endmodule

// File: tb/test_i2cpk_master.sv
module test_i2cpk_master;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [6:0] SLV = 7'h52;

  typedef struct packed {
    logic        rd;
    logic [3:0]  n;
    logic [31:0] w0;
    logic [31:0] w1;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 4'd1, 32'hFFFF_FF5A, 32'h0},
    '{1'b0, 4'd4, 32'h4433_2211, 32'h0},
    '{1'b0, 4'd6, 32'hDDCC_BBAA, 32'h9999_0F0E},
    '{1'b1, 4'd1, 32'h0, 32'h0},
    '{1'b1, 4'd5, 32'h0, 32'h0},
    '{1'b0, 4'd8, 32'h8765_4321, 32'h0FED_CBA9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [31:0] tx_data = '0;
  logic [2:0] sts_clr = '0;
  logic tx_ready, rx_valid, scl_o, sda_oe;
  logic [31:0] rx_data;
  logic [CW-1:0] tx_free, rx_fill;
  logic [2:0] irq_sts;
  logic s_oe = 1'b0, pull_low = 1'b0;
  wire  sda_bus = !(sda_oe || s_oe || pull_low);

  always #10 clk = ~clk;

  i2cpk_master #(.FIFO_DEPTH(DEPTH)) i_i2cpk_master (
    .clk, .rst_n, .scl_half(16'd2), .tx_valid, .tx_ready, .tx_data,
    .rx_valid, .rx_ready, .rx_data, .tx_free, .rx_fill, .irq_sts, .sts_clr,
    .scl_o, .sda_oe, .sda_i(sda_bus));

  int errs = 0, checks = 0, cyc = 0;
  bit finished = 0;

  // slave model and bus logs
  int bitn = 0, byten = 0, wn = 0, mn = 0, starts = 0, stops = 0, rcnt = 0;
  bit active = 0, skip_neg = 0, rdm = 0, addr_ok = 0, last_mack = 0;
  bit nack_addr = 0, nack_data = 0;
  logic [7:0] sh = '0, rdv = '0;
  logic [7:0] wlog [64];
  bit mack [64];

  function automatic logic [7:0] pat(int k);
    return 8'hC3 ^ 8'(k * 17);
  endfunction

  always @(negedge sda_bus) if (scl_o) begin
    active = 1; skip_neg = 1; bitn = 0; byten = 0; rcnt = 0; starts++; s_oe = 0;
  end
  always @(posedge sda_bus) if (scl_o) begin
    stops++; active = 0; s_oe = 0;
  end
  always @(posedge scl_o) if (active) begin
    if (bitn < 8) sh = {sh[6:0], sda_bus};
    else if (byten > 0 && rdm) begin mack[mn] = sda_bus; last_mack = sda_bus; mn++; end
  end
  always @(negedge scl_o) if (active) begin
    if (skip_neg) skip_neg = 0;
    else if (bitn < 8) begin
      bitn++;
      if (bitn == 8) begin
        if (byten == 0) begin
          wlog[wn] = sh; wn++; rdm = sh[0];
          addr_ok = (sh[7:1] == SLV) && !nack_addr; s_oe = addr_ok; last_mack = 0;
        end else if (!rdm) begin
          wlog[wn] = sh; wn++; s_oe = !nack_data;
        end else s_oe = 0;
      end else if (byten > 0 && rdm) s_oe = !rdv[7 - bitn];
    end else begin
      bitn = 0; byten++;
      if (rdm && addr_ok && !last_mack) begin
        rdv = pat(rcnt); rcnt++; s_oe = !rdv[7];
      end else s_oe = 0;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errs++; checks++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      summary();
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(logic [31:0] w);
    @(negedge clk); tx_valid = 1; tx_data = w;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic pop(output logic [31:0] w);
    @(negedge clk);
    for (int t = 0; t < 5000 && !rx_valid; t++) @(negedge clk);
    w = rx_data; rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); sts_clr = 3'b111;
    @(negedge clk); sts_clr = 3'b000;
  endtask

  int wn0, stp0, sta0, mn0;

  task automatic do_txn(bit rd, bit rs, int n, logic [31:0] w0, logic [31:0] w1);
    logic [31:0] h2;
    wn0 = wn; stp0 = stops; sta0 = starts; mn0 = mn;
    h2 = {8'h0, 4'h0, rd, 2'b00, rs, 8'h0, SLV, rd};
    push(32'h0001_1010);
    push(32'(n - 1));
    push(h2);
    if (!rd) begin
      push(w0);
      if (n > 4) push(w1);
    end
    @(negedge clk);
    for (int t = 0; t < 20000 && irq_sts == 3'b000; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] w, ew, hold;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(tx_free == CW'(DEPTH), "R10 tx_free", 32'(tx_free), DEPTH);
    chk(rx_fill == 0, "R10 rx_fill", 32'(rx_fill), 0);
    chk(irq_sts == 0, "R10 status", 32'(irq_sts), 0);
    chk(scl_o && !sda_oe, "R10 lines", {scl_o, sda_oe}, 2'b10);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      do_txn(VEC[v].rd, 1'b0, int'(VEC[v].n), VEC[v].w0, VEC[v].w1);
      chk(irq_sts == 3'b001, "R6 done", 32'(irq_sts), 1);
      chk(stops == stp0 + 1, "R6 stop", stops - stp0, 1);
      chk(tx_free == CW'(DEPTH), "R1 consumed", 32'(tx_free), DEPTH);
      chk(wlog[wn0] == {SLV, VEC[v].rd}, "R2 address", wlog[wn0], {SLV, VEC[v].rd});
      if (!VEC[v].rd) begin
        chk(wn == wn0 + 1 + int'(VEC[v].n), "R3 count", wn - wn0, 1 + VEC[v].n);
        for (int k = 0; k < int'(VEC[v].n); k++) begin
          ew = (k < 4) ? 32'(VEC[v].w0[8*k +: 8]) : 32'(VEC[v].w1[8*(k-4) +: 8]);
          chk(wlog[wn0 + 1 + k] == ew[7:0], "R3 byte", wlog[wn0 + 1 + k], ew);
        end
      end else begin
        chk(wn == wn0 + 1, "R2 read no write", wn - wn0, 1);
        chk(mn == mn0 + int'(VEC[v].n), "R4 ack count", mn - mn0, VEC[v].n);
        for (int k = 0; k < int'(VEC[v].n); k++)
          chk(mack[mn0 + k] == (k == int'(VEC[v].n) - 1), "R4 master ack", mack[mn0 + k], k == int'(VEC[v].n) - 1);
        for (int j = 0; j < (int'(VEC[v].n) + 3) / 4; j++) begin
          ew = '0;
          for (int b = 0; b < 4; b++)
            if (4*j + b < int'(VEC[v].n)) ew[8*b +: 8] = pat(4*j + b);
          pop(w);
          chk(w == ew, "R4 rx word", w, ew);
        end
        chk(rx_fill == 0, "R4 rx drained", 32'(rx_fill), 0);
      end
      clear_all();
    end

    // R9 write-one-to-clear
    do_txn(1'b0, 1'b0, 1, 32'h0000_0077, 32'h0);
    @(negedge clk); sts_clr = 3'b110;
    @(negedge clk); sts_clr = 3'b000;
    @(negedge clk);
    chk(irq_sts == 3'b001, "R9 zero keeps", 32'(irq_sts), 1);
    sts_clr = 3'b001;
    @(negedge clk); sts_clr = 3'b000;
    @(negedge clk);
    chk(irq_sts == 3'b000, "R9 one clears", 32'(irq_sts), 0);

    // R5 repeated start
    do_txn(1'b0, 1'b1, 1, 32'h0000_00E1, 32'h0);
    chk(irq_sts == 3'b001, "R5 done", 32'(irq_sts), 1);
    chk(stops == stp0, "R5 no stop", stops - stp0, 0);
    chk(!scl_o, "R5 scl held", scl_o, 0);
    clear_all();
    sta0 = starts;
    do_txn(1'b1, 1'b0, 1, 32'h0, 32'h0);
    pop(w);
    chk(starts == sta0 + 1 && stops == stp0 + 1, "R5 rstart", starts - sta0, 1);
    chk(w == {24'h0, pat(0)}, "R5 read after rstart", w, {24'h0, pat(0)});
    clear_all();

    // R11 rx hold
    do_txn(1'b1, 1'b0, 5, 32'h0, 32'h0);
    chk(rx_fill == 2 && rx_valid, "R11 rx fill", 32'(rx_fill), 2);
    hold = rx_data;
    repeat (5) @(negedge clk);
    chk(rx_data == hold, "R11 rx stable", rx_data, hold);
    pop(w); pop(w);
    clear_all();

    // R7 address nack, halt, back-pressure
    nack_addr = 1;
    do_txn(1'b0, 1'b0, 2, 32'h0000_3344, 32'h0);
    nack_addr = 0;
    chk(irq_sts == 3'b010, "R7 nack status", 32'(irq_sts), 2);
    chk(stops == stp0 + 1, "R7 stop", stops - stp0, 1);
    chk(tx_free == CW'(DEPTH - 1), "R7 word left", 32'(tx_free), DEPTH - 1);
    for (int k = 0; k < DEPTH - 1; k++) push(32'h1000 + 32'(k));
    @(negedge clk);
    chk(tx_free == 0 && !tx_ready, "R11 full", {tx_ready, 4'(tx_free)}, 0);
    repeat (300) @(negedge clk);
    chk(tx_free == 0, "R7 frozen", 32'(tx_free), 0);
    do_reset();
    chk(tx_free == CW'(DEPTH) && irq_sts == 0, "R10 flush", 32'(tx_free), DEPTH);

    // R7 data nack
    nack_data = 1;
    do_txn(1'b0, 1'b0, 3, 32'h0055_6677, 32'h0);
    nack_data = 0;
    chk(irq_sts == 3'b010, "R7 data nack", 32'(irq_sts), 2);
    chk(wn == wn0 + 2, "R7 stops after byte", wn - wn0, 2);
    do_reset();

    // R8 arbitration loss
    pull_low = 1;
    do_txn(1'b0, 1'b0, 1, 32'h0000_0011, 32'h0);
    chk(irq_sts == 3'b100, "R8 arb status", 32'(irq_sts), 4);
    chk(scl_o && !sda_oe, "R8 released", {scl_o, sda_oe}, 2'b10);
    pull_low = 0;
    do_reset();
    do_txn(1'b0, 1'b0, 2, 32'h0000_2B1A, 32'h0);
    chk(irq_sts == 3'b001 && wlog[wn0 + 2] == 8'h2B, "R3 after recovery", wlog[wn0 + 2], 8'h2B);

    summary();
  end
endmodule